// File: doc/BRIEF.md
# Pin-level I2C target to byte-request bridge

This block sits on the two sampled wires of an I2C bus, with SDA and SCL levels coming from a software-driven or GPIO-style controller. It acts as the target side of the bus and turns the pin activity into byte-level requests on a downstream request/response port. A START followed by eight clocked bits becomes an address-plus-direction request. Later bytes in the write direction become write requests. In the read direction a byte is fetched from downstream and shifted out MSB first. A STOP closes the transfer with an end request.

The block works on pin events and not on bus timing. Each system clock it handles at most one change of a pin against its stored level. Changes of SDA are handled before changes of SCL. All protocol work happens on SCL rising edges, and every SCL falling edge releases the block's own data drive. The SDA level returned to the controller is the wired-AND of the block's drive and the last SDA level written by the controller.

Downstream requests use a valid/ready handshake. While a request is waiting for `req_ready`, or a response is waiting for `rsp_valid`, the block holds its pin-event processing. A pin change that arrives in that window stays pending in the input comparison and is handled once the port is free. The controller must therefore leave enough system clocks between pin changes for the downstream side to answer. Start, write and read requests expect exactly one response beat, accepted while `rsp_ready` is high. End and nack requests take no response.

Top module: `i2c_pin_bridge`

## Requirements
- R1: After reset `sda_out` is 1, `req_valid` is 0 and `rsp_ready` is 0, and the stored SDA and SCL levels are both 1.
- R2: SDA falling while the stored SCL is 1 is a START and SDA rising while SCL is 1 is a STOP. An SDA change while SCL is 0 is only recorded: it raises no request and leaves the drive unchanged.
- R3: After a START, eight SCL rising edges shift SDA in MSB first. On the ninth rising edge a start request (`req_op`=0) is issued with `req_addr` set to bits 7..1 and `req_rd` set to bit 0.
- R4: In the acknowledge slot (ninth rising edge) the block drives SDA low once the response has `rsp_ack`=1, and leaves it high when `rsp_ack`=0. The drive is released to 1 on the next SCL falling edge.
- R5: In the write direction each later byte is shifted in the same way, and on its ninth rising edge a write request (`req_op`=1) is issued carrying the byte on `req_wdata`.
- R6: In the read direction a read request (`req_op`=2) is issued on the first rising edge of each byte. The returned byte is driven MSB first, one bit per SCL rising edge, with bit 7 appearing after the first edge.
- R7: On the rising edge after a read byte, a master SDA of 0 continues with the next read byte. A master SDA of 1 issues a nack request (`req_op`=4), after which SCL edges raise no request and `sda_out` follows the master level until the next START or STOP.
- R8: A STOP issues an end request (`req_op`=3) only if an address was captured since the last START. A STOP with no captured address raises no request.
- R9: `sda_out` is the AND of the block's drive and the stored master SDA level, so a master holding SDA low always reads 0.
- R10: `req_valid` and the request fields stay stable until `req_ready`. `rsp_ready` is raised only after a start, write or read request has been accepted, and drops after one response beat. End and nack requests never raise `rsp_ready`.
- R11: A repeated START without a STOP raises no end request and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_in | input | 1 | SDA level written by the controller |
| scl_in | input | 1 | SCL level written by the controller |
| sda_out | output | 1 | Wired-AND SDA level returned to the controller |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_op | output | 3 | 0 start, 1 write, 2 read, 3 end, 4 nack |
| req_addr | output | DATA_W-1 | Target address for a start request |
| req_rd | output | 1 | Read direction flag for a start request |
| req_wdata | output | DATA_W | Byte for a write request |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_ready | output | 1 | Block is waiting for a response beat |
| rsp_ack | input | 1 | Acknowledge for start and write requests |
| rsp_rdata | input | DATA_W | Byte returned for a read request |

## Verification
The bench builds the block with its default `DATA_W` of 8, which makes the shift counter wrap on a real I2C byte. With that width, seven-bit addresses with either direction bit, mixed acknowledge and not-acknowledge answers, and multi-byte reads ending in a master nack can all be driven from plain bit-bang tasks. The downstream model adds up to three cycles of back-pressure before it accepts a request. That exercises request holding and the stall of pending pin events, including a read byte that must arrive before its first bit is shown.

// File: rtl/i2c_pin_bridge_pkg.sv
package i2c_pin_bridge_pkg;
  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_END   = 3'd3,
    OP_NACK  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_STOP,
    EV_QUIET,
    EV_RISE,
    EV_FALL
  } ev_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT_IN,
    PH_ACK_SLOT,
    PH_SHIFT_OUT,
    PH_MACK,
    PH_NACKED
  } phase_e;

  typedef enum logic [1:0] {
    PD_NONE,
    PD_ACK,
    PD_READ
  } pend_e;
endpackage

// File: rtl/i2c_pin_edges.sv
module i2c_pin_edges
  import i2c_pin_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sda_in,
  input  logic scl_in,
  input  logic take,
  output ev_e  ev_kind,
  output logic sda_q,
  output logic scl_q
);
  // SDA changes win over SCL changes: one event per clock.
  logic sda_chg, scl_chg;
  assign sda_chg = sda_in != sda_q;
  assign scl_chg = scl_in != scl_q;

  always_comb begin
    ev_kind = EV_NONE;
    if (sda_chg) begin
      if (scl_q) ev_kind = sda_in ? EV_STOP : EV_START;
      else       ev_kind = EV_QUIET;
    end else if (scl_chg) begin
      ev_kind = scl_in ? EV_RISE : EV_FALL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else if (take) begin
      if (sda_chg)      sda_q <= sda_in;
      else if (scl_chg) scl_q <= scl_in;
    end
  end
endmodule

// File: rtl/i2c_req_port.sv
module i2c_req_port
  import i2c_pin_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  op_e               issue_op,
  input  logic [DATA_W-2:0] issue_addr,
  input  logic              issue_rd,
  input  logic [DATA_W-1:0] issue_data,
  output logic              req_valid,
  input  logic              req_ready,
  output op_e               req_op,
  output logic [DATA_W-2:0] req_addr,
  output logic              req_rd,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              rsp_fire,
  output logic              busy
);
  logic needs_rsp;
  assign needs_rsp = (req_op == OP_START) || (req_op == OP_WRITE) || (req_op == OP_READ);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign busy      = req_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_op    <= OP_END;
      req_addr  <= '0;
      req_rd    <= 1'b0;
      req_wdata <= '0;
      rsp_ready <= 1'b0;
    end else begin
      if (issue) begin
        req_valid <= 1'b1;
        req_op    <= issue_op;
        req_addr  <= issue_addr;
        req_rd    <= issue_rd;
        req_wdata <= issue_data;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        rsp_ready <= needs_rsp;
      end
      if (rsp_fire) rsp_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_pin_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ev_e               ev_kind,
  input  logic              sda_q,
  input  logic              busy,
  input  logic              rsp_fire,
  input  logic              rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              take,
  output logic              issue,
  output op_e               issue_op,
  output logic [DATA_W-2:0] issue_addr,
  output logic              issue_rd,
  output logic [DATA_W-1:0] issue_data,
  output logic              drive
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(DATA_W - 1);

  phase_e            ph, ph_n;
  pend_e             pend, pend_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              drv_n, have_addr, have_n, rd_dir, rd_n;

  assign take       = (ev_kind != EV_NONE) && !busy;
  assign issue_addr = sh[DATA_W-1:1];
  assign issue_rd   = sh[0];
  assign issue_data = sh;

  always_comb begin
    ph_n = ph; pend_n = pend; cnt_n = cnt; sh_n = sh;
    drv_n = drive; have_n = have_addr; rd_n = rd_dir;
    issue = 1'b0; issue_op = OP_END;
    if (rsp_fire) begin
      pend_n = PD_NONE;
      if (pend == PD_ACK) begin
        drv_n = !rsp_ack;
      end else if (pend == PD_READ) begin
        drv_n = rsp_rdata[DATA_W-1];
        sh_n  = {rsp_rdata[DATA_W-2:0], 1'b0};
      end
    end else if (take) begin
      unique case (ev_kind)
        EV_START: begin
          ph_n = PH_SHIFT_IN; cnt_n = TOP_BIT; have_n = 1'b0; drv_n = 1'b1;
        end
        EV_STOP: begin
          if (have_addr) begin issue = 1'b1; issue_op = OP_END; end
          ph_n = PH_IDLE; have_n = 1'b0; drv_n = 1'b1;
        end
        EV_FALL: drv_n = 1'b1;
        EV_RISE: begin
          unique case (ph)
            PH_SHIFT_IN: begin
              sh_n  = {sh[DATA_W-2:0], sda_q};
              drv_n = 1'b1;
              if (cnt == '0) ph_n = PH_ACK_SLOT;
              else           cnt_n = cnt - 1'b1;
            end
            PH_ACK_SLOT: begin
              issue  = 1'b1;
              pend_n = PD_ACK;
              cnt_n  = TOP_BIT;
              if (!have_addr) begin
                issue_op = OP_START;
                have_n   = 1'b1;
                rd_n     = sh[0];
                ph_n     = sh[0] ? PH_SHIFT_OUT : PH_SHIFT_IN;
              end else begin
                issue_op = OP_WRITE;
                ph_n     = rd_dir ? PH_SHIFT_OUT : PH_SHIFT_IN;
              end
            end
            PH_SHIFT_OUT: begin
              if (cnt == TOP_BIT) begin
                issue = 1'b1; issue_op = OP_READ; pend_n = PD_READ;
              end else begin
                drv_n = sh[DATA_W-1];
                sh_n  = {sh[DATA_W-2:0], 1'b0};
              end
              if (cnt == '0) ph_n = PH_MACK;
              else           cnt_n = cnt - 1'b1;
            end
            PH_MACK: begin
              drv_n = 1'b1;
              if (sda_q) begin
                ph_n = PH_NACKED; issue = 1'b1; issue_op = OP_NACK;
              end else begin
                ph_n = PH_SHIFT_OUT; cnt_n = TOP_BIT;
              end
            end
            default: drv_n = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; pend <= PD_NONE; cnt <= TOP_BIT; sh <= '0;
      drive <= 1'b1; have_addr <= 1'b0; rd_dir <= 1'b0;
    end else begin
      ph <= ph_n; pend <= pend_n; cnt <= cnt_n; sh <= sh_n;
      drive <= drv_n; have_addr <= have_n; rd_dir <= rd_n;
    end
  end
endmodule

// File: rtl/i2c_pin_bridge.sv
module i2c_pin_bridge
  import i2c_pin_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_out,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_op,
  output logic [DATA_W-2:0] req_addr,
  output logic              req_rd,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ack,
  input  logic [DATA_W-1:0] rsp_rdata
);
  ev_e               ev_kind;
  op_e               issue_op, req_op_e;
  logic              sda_q, scl_q, take, issue, issue_rd, drive, busy, rsp_fire;
  logic [DATA_W-2:0] issue_addr;
  logic [DATA_W-1:0] issue_data;

  i2c_pin_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .take(take), .ev_kind(ev_kind), .sda_q(sda_q), .scl_q(scl_q)
  );

  i2c_target_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_kind(ev_kind), .sda_q(sda_q), .busy(busy),
    .rsp_fire(rsp_fire), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .take(take), .issue(issue), .issue_op(issue_op), .issue_addr(issue_addr),
    .issue_rd(issue_rd), .issue_data(issue_data), .drive(drive)
  );

  i2c_req_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_op(issue_op),
    .issue_addr(issue_addr), .issue_rd(issue_rd), .issue_data(issue_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op_e),
    .req_addr(req_addr), .req_rd(req_rd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fire(rsp_fire), .busy(busy)
  );

  assign req_op  = req_op_e;
  assign sda_out = drive & sda_q;
endmodule

// File: rtl/i2c_pin_bridge_chk.sv
module i2c_pin_bridge_chk
  import i2c_pin_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_in,
  input logic              sda_out,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [DATA_W-2:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_ready,
  input logic              take,
  input ev_e               ev_kind
);
  logic open_xfer;
  always_ff @(posedge clk) begin
    if (!rst_n) open_xfer <= 1'b0;
    else if (req_valid && req_ready) begin
      if (req_op == 3'd0)      open_xfer <= 1'b1;
      else if (req_op == 3'd3) open_xfer <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_wdata)); // R10
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready && req_op <= 3'd2)); // R10
  AST_END_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 3'd3 |-> open_xfer); // R8
  AST_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    take && ev_kind == EV_FALL |=> sda_out == $past(sda_in)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    take && ev_kind == EV_STOP |=> sda_out); // R2
  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take && ev_kind == EV_QUIET |=> !req_valid); // R2
endmodule

bind i2c_pin_bridge i2c_pin_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .sda_out(sda_out),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
  .take(take), .ev_kind(ev_kind)
);

// File: tb/test_i2c_pin_bridge.sv
module test_i2c_pin_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int DATA_W = 8;

  logic clk, rst_n, sda_in, scl_in, sda_out;
  logic req_valid, req_ready, req_rd, rsp_valid, rsp_ready, rsp_ack;
  logic [2:0] req_op;
  logic [DATA_W-2:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_rdata;

  i2c_pin_bridge #(.DATA_W(DATA_W)) i_i2c_pin_bridge (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in), .sda_out(sda_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_rd(req_rd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [6:0] addr;
    logic       rd;
    logic [7:0] data;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] rd_q[$];
  logic       dn_ack;
  int         checks, fails;
  bit         finished;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic expect_req(input logic [2:0] op, input logic [6:0] a, input logic r, input logic [7:0] d);
    item_t it;
    it.op = op; it.addr = a; it.rd = r; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic pins(input logic s, input logic c);
    @(negedge clk);
    sda_in = s;
    scl_in = c;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic start_cond();
    pins(1'b1, scl_in);
    pins(1'b1, 1'b1);
    pins(1'b0, 1'b1);
    pins(1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    pins(1'b0, scl_in);
    pins(1'b0, 1'b1);
    pins(1'b1, 1'b1);
    chk("R2 sda after stop", sda_out, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack);
    for (int i = 7; i >= 0; i--) begin
      pins(b[i], 1'b0);
      pins(b[i], 1'b1);
      chk("R9 sda_out follows master bit", sda_out, b[i]);
      pins(b[i], 1'b0);
    end
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    chk("R4 ack slot level", sda_out, !exp_ack);
    pins(1'b1, 1'b0);
    chk("R4 release after ack", sda_out, 1'b1);
  endtask

  task automatic recv_byte(input logic [7:0] exp_b, input logic m_ack);
    for (int i = 7; i >= 0; i--) begin
      pins(1'b1, 1'b0);
      pins(1'b1, 1'b1);
      chk("R6 read bit", sda_out, exp_b[i]);
      pins(1'b1, 1'b0);
    end
    pins(!m_ack, 1'b0);
    pins(!m_ack, 1'b1);
    chk("R7 master ack slot", sda_out, !m_ack);
    pins(!m_ack, 1'b0);
    pins(1'b1, 1'b0);
  endtask

  // downstream model and scoreboard monitor
  initial begin
    int bp;
    bp = 0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_ack = 1'b0; rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        logic [2:0] op;
        item_t e;
        op = req_op;
        repeat (bp) @(negedge clk);
        bp = (bp + 1) % 4;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 unexpected request actual op=%0d expected none", req_op);
        end else begin
          e = exp_q.pop_front();
          chk("R10 request op", req_op, e.op);
          case (e.op)
            3'd0: begin chk("R3 start addr", req_addr, e.addr); chk("R3 start rd", req_rd, e.rd); end
            3'd1: chk("R5 write data", req_wdata, e.data);
            3'd2: chk("R6 read op", req_op, 3'd2);
            3'd3: chk("R8 end op", req_op, 3'd3);
            default: chk("R7 nack op", req_op, 3'd4);
          endcase
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (op <= 3'd2) begin
          chk("R10 rsp_ready after request", rsp_ready, 1'b1);
          rsp_valid = 1'b1;
          rsp_ack = dn_ack;
          rsp_rdata = (op == 3'd2 && rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
          @(negedge clk);
          rsp_valid = 1'b0;
        end else begin
          chk("R10 no response for end/nack", rsp_ready, 1'b0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; finished = 1'b0; dn_ack = 1'b1;
    rst_n = 1'b0; sda_in = 1'b1; scl_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset sda_out", sda_out, 1'b1);
    chk("R1 reset req_valid", req_valid, 1'b0);
    chk("R1 reset rsp_ready", rsp_ready, 1'b0);

    // R2: SDA changes with SCL low are recorded only
    pins(1'b1, 1'b0);
    pins(1'b0, 1'b0);
    chk("R2 quiet sda low", sda_out, 1'b0);
    chk("R2 quiet no request", req_valid, 1'b0);
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    chk("R2 idle rise", sda_out, 1'b1);
    // R8: START then STOP with no address -> no end request
    pins(1'b0, 1'b1);
    pins(1'b1, 1'b1);
    chk("R8 bare stop no request", req_valid, 1'b0);
    chk("R8 bare stop queue", exp_q.size(), 0);

    // write transfer
    expect_req(3'd0, 7'h50, 1'b0, 8'h00);
    start_cond();
    send_byte(8'hA0, 1'b1);
    expect_req(3'd1, 7'h00, 1'b0, 8'h3C);
    send_byte(8'h3C, 1'b1);
    dn_ack = 1'b0;
    expect_req(3'd1, 7'h00, 1'b0, 8'hC5);
    send_byte(8'hC5, 1'b0);
    dn_ack = 1'b1;
    expect_req(3'd3, 7'h00, 1'b0, 8'h00);
    stop_cond();
    chk("R8 end consumed", exp_q.size(), 0);

    // read transfer ending in master nack
    expect_req(3'd0, 7'h2A, 1'b1, 8'h00);
    start_cond();
    send_byte(8'h55, 1'b1);
    expect_req(3'd2, 7'h00, 1'b0, 8'h00);
    rd_q.push_back(8'h96);
    recv_byte(8'h96, 1'b1);
    expect_req(3'd2, 7'h00, 1'b0, 8'h00);
    expect_req(3'd4, 7'h00, 1'b0, 8'h00);
    rd_q.push_back(8'h5B);
    recv_byte(8'h5B, 1'b0);
    pins(1'b0, 1'b0);
    pins(1'b0, 1'b1);
    chk("R7 ignored clock follows master low", sda_out, 1'b0);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    chk("R7 ignored clock follows master high", sda_out, 1'b1);
    pins(1'b1, 1'b0);
    chk("R7 no request after nack", exp_q.size(), 0);
    expect_req(3'd3, 7'h00, 1'b0, 8'h00);
    stop_cond();

    // R11: repeated START
    expect_req(3'd0, 7'h22, 1'b0, 8'h00);
    start_cond();
    send_byte(8'h44, 1'b1);
    expect_req(3'd1, 7'h00, 1'b0, 8'h01);
    send_byte(8'h01, 1'b1);
    expect_req(3'd0, 7'h23, 1'b1, 8'h00);
    start_cond();
    send_byte(8'h47, 1'b1);
    expect_req(3'd2, 7'h00, 1'b0, 8'h00);
    expect_req(3'd4, 7'h00, 1'b0, 8'h00);
    rd_q.push_back(8'hE1);
    recv_byte(8'hE1, 1'b0);
    expect_req(3'd3, 7'h00, 1'b0, 8'h00);
    stop_cond();

    repeat (20) @(negedge clk);
    chk("R11 all requests seen once", exp_q.size(), 0);
    finish_run();
  end
endmodule